// File: doc/BRIEF.md
# Camera Flash Pulse Controller

This block drives one flash output for an image sensor. It follows frame-phase strobes from the sensor timing generator and produces either a long LED-style enable or a timed xenon-style pulse. The LED enable spans from the start of a frame's reset phase to the end of that frame's readout. The xenon pulse is timed in coarse ticks of the pixel clock and starts at a chosen trigger point.

The flash can fire on every frame or on one frame only. It can be held back by a number of frames after it is armed. A status output tells whether the flash was lit during the current frame. Exposure control and register access stay outside the block; its controls arrive as plain static inputs.

Top module: `flash_ctrl`

## Requirements
- R1: After reset `flash_o` and `triggered_o` are 0.
- R2: In xenon mode with a count N between 1 and 254, `flash_o` is high for exactly N × TICK_CYCLES clock cycles. TICK_CYCLES defaults to 1024.
- R3: Any xenon pulse ends in the cycle after `first_row_i` is sampled. With a count of 0xFF the pulse has no timer and runs from its start to that point.
- R4: With `trig_end_reset_i`=1 a xenon pulse starts in the cycle after `reset_done_i` is sampled. With 0 it starts in the cycle after `readout_done_i` is sampled. It starts only in a firing frame.
- R5: In LED mode `flash_o` rises in the cycle after `frame_start_i` is sampled in a firing frame. It falls in the cycle after `readout_done_i` is sampled.
- R6: With `every_frame_i`=1 every frame after the delay fires. With 0 only one frame fires.
- R7: With `frame_delay_i`=D, the first D frames after arming do not fire and frame D+1 does.
- R8: A one-shot flash re-arms only when the OR of the two mode enables goes from 0 to 1.
- R9: When `xenon_en_i` and `led_en_i` are both 1, xenon mode is used and LED mode has no effect.
- R10: `triggered_o` is high in every cycle that `flash_o` is high. It stays high until the next `frame_start_i` is sampled, and then clears unless `flash_o` is high.
- R11: When both enables are 0, `flash_o` is 0 from the next cycle on.
- R12: A xenon count of 0 gives no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| frame_start_i | input | 1 | One-cycle strobe: the frame's reset phase begins |
| reset_done_i | input | 1 | One-cycle strobe: the frame's reset phase ends |
| first_row_i | input | 1 | One-cycle strobe: readout of the first row begins |
| readout_done_i | input | 1 | One-cycle strobe: frame readout ends |
| xenon_cnt_i | input | 8 | Xenon pulse length in ticks; 0xFF runs until first-row readout |
| led_en_i | input | 1 | LED mode enable |
| xenon_en_i | input | 1 | Xenon mode enable (has priority) |
| every_frame_i | input | 1 | 1: fire each frame, 0: fire once |
| trig_end_reset_i | input | 1 | Xenon trigger point: 1 after reset, 0 after readout |
| frame_delay_i | input | 2 | Frames to skip after arming |
| flash_o | output | 1 | Flash drive |
| triggered_o | output | 1 | Flash was lit in the current frame |

## Verification
The LED mode is run as a repeating stream and as a delayed one-shot. These runs separate the every-frame path, the delay countdown and the re-arm on an enable edge. The xenon mode is run with a mid-range count that ends by timer, a saturated count and a long count that end at the first row, and a zero count. The exact cycle counts separate the tick timer from the truncation path. Switching the trigger selector, and turning on both enables at once, show the start point and the mode priority. The status output is read at the end of firing and non-firing frames.

// File: rtl/flash_pkg.sv
package flash_pkg;
  typedef enum logic [1:0] {
    FM_OFF   = 2'd0,
    FM_LED   = 2'd1,
    FM_XENON = 2'd2
  } flash_mode_e;
endpackage

// File: rtl/flash_arm.sv
module flash_arm #(
  parameter int DLY_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             frame_start_i,
  input  logic             every_frame_i,
  input  logic [DLY_W-1:0] frame_delay_i,
  output logic             fire_frame_o,
  output logic             fire_start_o
);
  logic             en_q, pending_q, fire_q;
  logic [DLY_W-1:0] dly_q;
  logic             en_rise;

  assign en_rise      = en_i & ~en_q;
  assign fire_start_o = frame_start_i & en_i & en_q & pending_q & (dly_q == '0);
  assign fire_frame_o = fire_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q      <= 1'b0;
      pending_q <= 1'b0;
      fire_q    <= 1'b0;
      dly_q     <= '0;
    end else begin
      en_q <= en_i;
      if (!en_i) begin
        pending_q <= 1'b0;
        fire_q    <= 1'b0;
      end else if (en_rise) begin
        pending_q <= 1'b1;
        dly_q     <= frame_delay_i;
        fire_q    <= 1'b0;
      end else if (frame_start_i) begin
        if (pending_q && dly_q != '0) begin
          dly_q  <= dly_q - 1'b1;
          fire_q <= 1'b0;
        end else if (pending_q) begin
          fire_q <= 1'b1;
          if (!every_frame_i) pending_q <= 1'b0;
        end else begin
          fire_q <= 1'b0;
        end
      end
    end
  end

  // R7
  fire_needs_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fire_q) |-> $past(frame_start_i));
  // R11
  fire_drops_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !fire_q);
endmodule

// File: rtl/flash_xenon_timer.sv
module flash_xenon_timer #(
  parameter int CNT_W       = 8,
  parameter int TICK_CYCLES = 1024
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             active_i,
  input  logic             fire_frame_i,
  input  logic             trig_i,
  input  logic             first_row_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             on_o
);
  localparam int PRE_W = (TICK_CYCLES > 2) ? $clog2(TICK_CYCLES) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_CYCLES - 1);

  logic             on_q, sat_q;
  logic [PRE_W-1:0] pre_q;
  logic [CNT_W-1:0] left_q;
  logic             start;

  assign start = active_i & fire_frame_i & trig_i & ~on_q & (cnt_i != '0);
  assign on_o  = on_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      on_q   <= 1'b0;
      sat_q  <= 1'b0;
      pre_q  <= '0;
      left_q <= '0;
    end else if (!active_i) begin
      on_q <= 1'b0;
    end else if (start) begin
      on_q   <= 1'b1;
      sat_q  <= (cnt_i == '1);
      pre_q  <= '0;
      left_q <= cnt_i;
    end else if (on_q) begin
      if (first_row_i) begin
        on_q <= 1'b0;
      end else if (!sat_q) begin
        if (pre_q == PRE_LAST) begin
          pre_q  <= '0;
          left_q <= left_q - 1'b1;
          if (left_q == CNT_W'(1)) on_q <= 1'b0;
        end else begin
          pre_q <= pre_q + 1'b1;
        end
      end
    end
  end

  // R3
  xe_trunc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (on_q && first_row_i) |=> !on_q);
  // R4
  xe_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(on_q) |-> $past(trig_i && fire_frame_i));
endmodule

// File: rtl/flash_led_gate.sv
module flash_led_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic active_i,
  input  logic fire_start_i,
  input  logic readout_done_i,
  output logic on_o
);
  logic on_q;
  assign on_o = on_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             on_q <= 1'b0;
    else if (!active_i)      on_q <= 1'b0;
    else if (fire_start_i)   on_q <= 1'b1;
    else if (readout_done_i) on_q <= 1'b0;
  end

  // R5
  led_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (on_q && readout_done_i && !fire_start_i) |=> !on_q);
endmodule

// File: rtl/flash_ctrl.sv
module flash_ctrl
  import flash_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int DLY_W       = 2,
  parameter int TICK_CYCLES = 1024
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             frame_start_i,
  input  logic             reset_done_i,
  input  logic             first_row_i,
  input  logic             readout_done_i,
  input  logic [CNT_W-1:0] xenon_cnt_i,
  input  logic             led_en_i,
  input  logic             xenon_en_i,
  input  logic             every_frame_i,
  input  logic             trig_end_reset_i,
  input  logic [DLY_W-1:0] frame_delay_i,
  output logic             flash_o,
  output logic             triggered_o
);
  flash_mode_e mode;
  logic fire_frame, fire_start, xe_on, led_on, xe_trig, trig_q;

  // xenon wins over LED
  always_comb begin
    if (xenon_en_i)    mode = FM_XENON;
    else if (led_en_i) mode = FM_LED;
    else               mode = FM_OFF;
  end

  assign xe_trig = trig_end_reset_i ? reset_done_i : readout_done_i;

  flash_arm #(.DLY_W(DLY_W)) i_arm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .en_i          (mode != FM_OFF),
    .frame_start_i (frame_start_i),
    .every_frame_i (every_frame_i),
    .frame_delay_i (frame_delay_i),
    .fire_frame_o  (fire_frame),
    .fire_start_o  (fire_start)
  );

  flash_xenon_timer #(.CNT_W(CNT_W), .TICK_CYCLES(TICK_CYCLES)) i_xenon (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .active_i     (mode == FM_XENON),
    .fire_frame_i (fire_frame),
    .trig_i       (xe_trig),
    .first_row_i  (first_row_i),
    .cnt_i        (xenon_cnt_i),
    .on_o         (xe_on)
  );

  flash_led_gate i_led (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .active_i       (mode == FM_LED),
    .fire_start_i   (fire_start),
    .readout_done_i (readout_done_i),
    .on_o           (led_on)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            trig_q <= 1'b0;
    else if (frame_start_i) trig_q <= 1'b0;
    else if (flash_o)       trig_q <= 1'b1;
  end

  assign flash_o     = xe_on | led_on;
  assign triggered_o = trig_q | flash_o;

  // R9
  xenon_prio_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xenon_en_i |=> !led_on);
  // R11
  off_when_dis_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!led_en_i && !xenon_en_i) |=> !flash_o);
  // R10
  status_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (triggered_o && !frame_start_i) |=> triggered_o);
endmodule

// File: tb/test_flash_ctrl.sv
module test_flash_ctrl;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       frame_start_i = 0, reset_done_i = 0, first_row_i = 0, readout_done_i = 0;
  logic [7:0] xenon_cnt_i = 0;
  logic       led_en_i = 0, xenon_en_i = 0, every_frame_i = 0, trig_end_reset_i = 0;
  logic [1:0] frame_delay_i = 0;
  logic       flash_o, triggered_o;

  int n_chk = 0, n_fail = 0, hi_cnt = 0;
  bit a_fs, a_rst, a_row, a_rdone, trg;
  int hi;

  always #2.5 clk_i = ~clk_i;

  flash_ctrl i_flash_ctrl (.*);

  always @(posedge clk_i) if (flash_o) hi_cnt++;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk_i) s = 1'b1;
    @(negedge clk_i) s = 1'b0;
  endtask

  task automatic idle(input int k);
    repeat (k) @(negedge clk_i);
  endtask

  task automatic run_frame(input int int_gap, input int vb_gap);
    int h0;
    @(negedge clk_i);
    h0 = hi_cnt;
    pulse(frame_start_i);  a_fs = flash_o;
    idle(4);
    pulse(reset_done_i);   a_rst = flash_o;
    idle(int_gap);
    pulse(first_row_i);    a_row = flash_o;
    idle(8);
    pulse(readout_done_i); a_rdone = flash_o;
    idle(vb_gap);
    trg = triggered_o;
    hi = hi_cnt - h0;
  endtask

  task automatic t_reset();
    chk("R1 flash", flash_o, 0);
    chk("R1 triggered", triggered_o, 0);
  endtask

  task automatic t_led_every();
    every_frame_i = 1; frame_delay_i = 0;
    @(negedge clk_i) led_en_i = 1;
    idle(2);
    for (int f = 0; f < 2; f++) begin
      run_frame(20, 10);
      chk("R5 rise", a_fs, 1);
      chk("R5 fall", a_rdone, 0);
      chk("R6 every", (hi > 0), 1);
      chk("R10 status", trg, 1);
    end
    @(negedge clk_i) led_en_i = 0;
    idle(2);
  endtask

  task automatic t_led_oneshot();
    every_frame_i = 0; frame_delay_i = 2;
    @(negedge clk_i) led_en_i = 1;
    idle(2);
    run_frame(20, 10); chk("R7 skip1", hi, 0);
    run_frame(20, 10); chk("R7 skip2", hi, 0);
    run_frame(20, 10);
    chk("R7 fire", a_fs, 1);
    chk("R10 set", trg, 1);
    run_frame(20, 10);
    chk("R6 oneshot", hi, 0);
    chk("R10 clear", trg, 0);
  endtask

  task automatic t_rearm();
    run_frame(20, 10); chk("R8 no rearm", hi, 0);
    frame_delay_i = 0;
    @(negedge clk_i) led_en_i = 0;
    idle(2);
    @(negedge clk_i) led_en_i = 1;
    idle(2);
    run_frame(20, 10); chk("R8 rearm", (hi > 0), 1);
    @(negedge clk_i) led_en_i = 0;
    idle(2);
  endtask

  task automatic t_xe_len();
    every_frame_i = 1; trig_end_reset_i = 1; xenon_cnt_i = 8'd2;
    @(negedge clk_i) xenon_en_i = 1;
    idle(2);
    run_frame(3000, 10);
    chk("R4 not at fs", a_fs, 0);
    chk("R4 at reset end", a_rst, 1);
    chk("R2 length", hi, 2048);
  endtask

  task automatic t_xe_trunc();
    xenon_cnt_i = 8'hFF;
    run_frame(600, 10);
    chk("R3 sat len", hi, 602);
    chk("R3 sat end", a_row, 0);
    xenon_cnt_i = 8'd5;
    run_frame(600, 10);
    chk("R3 trunc len", hi, 602);
  endtask

  task automatic t_xe_readout();
    trig_end_reset_i = 0; xenon_cnt_i = 8'd1;
    run_frame(50, 1100);
    chk("R4 not at reset", a_rst, 0);
    chk("R4 at readout", a_rdone, 1);
    chk("R2 one tick", hi, 1024);
  endtask

  task automatic t_prio();
    trig_end_reset_i = 1; xenon_cnt_i = 8'd1;
    @(negedge clk_i) led_en_i = 1;
    run_frame(1200, 10);
    chk("R9 no led", a_fs, 0);
    chk("R9 xenon len", hi, 1024);
    @(negedge clk_i) led_en_i = 0;
  endtask

  task automatic t_zero();
    xenon_cnt_i = 8'd0;
    run_frame(100, 10);
    chk("R12 zero", hi, 0);
  endtask

  task automatic t_disable();
    xenon_cnt_i = 8'hFF;
    pulse(frame_start_i);
    idle(4);
    pulse(reset_done_i);
    chk("R11 pre", flash_o, 1);
    @(negedge clk_i) xenon_en_i = 0;
    @(negedge clk_i);
    chk("R11 off", flash_o, 0);
    pulse(first_row_i);
    pulse(readout_done_i);
  endtask

  initial begin
    fork
      begin
        idle(3);
        rst_ni = 1'b1;
        idle(2);
        t_reset();
        t_led_every();
        t_led_oneshot();
        t_rearm();
        t_xe_len();
        t_xe_trunc();
        t_xe_readout();
        t_prio();
        t_zero();
        t_disable();
      end
      begin
        repeat (150000) @(posedge clk_i);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule